// File: doc/BRIEF.md
# Six-Pin GPIO Port with Serial-Channel Direction Override

This block is a small general-purpose I/O port of six pins. Software sets a direction bit and an output data bit for each pin through a simple register interface. It reads the pin levels back after they pass through a two-flop synchronizer. The read data is combinational from the address. A write takes effect at the next rising clock edge.

An on-chip serial channel can take over a pin. Each pin has a transmit enable and a receive enable. While transmit is enabled, the pin is driven as an output and carries the channel's transmit bit. While receive is enabled, the pin is held as an input. If both are enabled, transmit wins. The stored direction bit is not changed by any of this. When the channel lets go of the pin, the stored direction bit controls the pin again.

Top module: `gpio_port_ovr`

## Requirements
- R1: Address 2 is the direction register. Bits 5..0 hold the direction bits, one per pin, with bit i controlling pin i. Bits 7 and 6 always read 0.
- R2: After a synchronous active-low reset, the following hold:
  - the direction bits and data bits are 0;
  - every pin has pin_oe = 0;
  - address 1 reads 0 until new pin levels pass the synchronizer.
- R3: With no channel enabled on pin i, the direction bit controls the pin:
  - direction bit 1 gives pin_oe[i] = 1 and pin_out[i] = data bit i;
  - direction bit 0 gives pin_oe[i] = 0.
- R4: Writes to the direction register (address 2) and the data register (address 0) are accepted in any cycle. The new value reads back from the cycle after the write edge.
- R5: While per_tx_en[i] = 1, pin i has pin_oe[i] = 1 and pin_out[i] = per_tx_data[i], whatever its direction bit holds.
- R6: While per_rx_en[i] = 1 and per_tx_en[i] = 0, pin i has pin_oe[i] = 0, whatever its direction bit holds.
- R7: Channel enables never change the stored direction bits. When both enables of a pin drop, the pin follows its stored direction bit again.
- R8: Address 1 returns the synchronized pin levels. A level present at rising edge k reads back after edge k+1 (two flops).
- R9: Address 0 reads, for each pin, one of two values:
  - the data register bit when pin_oe is 1;
  - the synchronized pin level when pin_oe is 0.
- R10: When per_tx_en[i] and per_rx_en[i] are both 1, transmit has priority: pin_oe[i] = 1 and pin_out[i] = per_tx_data[i].
- R11: Writes to address 1 or address 3 change no register. Address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 data, 1 input, 2 direction, 3 reserved |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 6 | Pin levels from the pads |
| pin_out | output | 6 | Pin output values |
| pin_oe | output | 6 | Pin output enables, 1 = drive |
| per_tx_en | input | 6 | Per-pin serial transmit channel enable |
| per_rx_en | input | 6 | Per-pin serial receive channel enable |
| per_tx_data | input | 6 | Per-pin serial transmit bit |

## Verification
The bench goes after five corner cases:
- A pin whose direction bit disagrees with an active channel. A design that ignored the override would float a transmit pin or drive against a receive pin.
- Transmit and receive enabled together on one pin. Wrong priority would turn the pin into an input.
- Releasing the channel afterwards. This shows whether the stored direction bit survived or was overwritten.
- Pin levels that change every cycle. A one-flop or three-flop path shows up as a one-cycle shift in the input and data readback.
- Writes to the read-only and reserved addresses. These would corrupt the data or direction register if decoded loosely.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DATA = 2'd0,
        ADDR_IN   = 2'd1,
        ADDR_DIR  = 2'd2,
        ADDR_RSV  = 2'd3
    } addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out = st_q.s2;

    // Counts the edges since reset, saturating at 2, so the check only
    // looks back over cycles that followed reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assert_sync_two_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (q_out == $past(d_in, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wbits,
    output logic [N-1:0]      ddr_q,
    output logic [N-1:0]      dat_q
);
    typedef struct packed {
        logic [N-1:0] ddr;
        logic [N-1:0] dat;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                ADDR_DIR:  r_d.ddr = wbits;
                ADDR_DATA: r_d.dat = wbits;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ddr_q = r_q.ddr;
    assign dat_q = r_q.dat;

    assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DIR) |=> (ddr_q == $past(wbits)));

    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_DIR) |=> $stable(ddr_q));

    assert_ignored_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_IN || addr == ADDR_RSV)) |=> ($stable(ddr_q) && $stable(dat_q)));
endmodule

// File: rtl/gpio_dir_mux.sv
module gpio_dir_mux #(
    parameter int N = 6
) (
    input  logic [N-1:0] ddr,
    input  logic [N-1:0] dat,
    input  logic [N-1:0] tx_en,
    input  logic [N-1:0] rx_en,
    input  logic [N-1:0] tx_data,
    output logic [N-1:0] oe,
    output logic [N-1:0] out
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            if (tx_en[i]) begin
                oe[i]  = 1'b1;
                out[i] = tx_data[i];
            end else if (rx_en[i]) begin
                oe[i]  = 1'b0;
                out[i] = dat[i];
            end else begin
                oe[i]  = ddr[i];
                out[i] = dat[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_pkg::*;
#(
    parameter int N_PINS = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    input  logic [N_PINS-1:0] per_tx_en,
    input  logic [N_PINS-1:0] per_rx_en,
    input  logic [N_PINS-1:0] per_tx_data
);
    localparam int PAD_W = DATA_W - N_PINS;

    logic [N_PINS-1:0] ddr_q, dat_q, sync_lvl;
    logic [N_PINS-1:0] rd_bits;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:N_PINS];

    gpio_regs #(.N(N_PINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wbits (wdata[N_PINS-1:0]),
        .ddr_q (ddr_q),
        .dat_q (dat_q)
    );

    gpio_sync #(.W(N_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (sync_lvl)
    );

    gpio_dir_mux #(.N(N_PINS)) u_mux (
        .ddr     (ddr_q),
        .dat     (dat_q),
        .tx_en   (per_tx_en),
        .rx_en   (per_rx_en),
        .tx_data (per_tx_data),
        .oe      (pin_oe),
        .out     (pin_out)
    );

    always_comb begin
        case (addr)
            ADDR_DATA: rd_bits = (pin_oe & dat_q) | (~pin_oe & sync_lvl);
            ADDR_IN:   rd_bits = sync_lvl;
            ADDR_DIR:  rd_bits = ddr_q;
            default:   rd_bits = '0;
        endcase
    end

    assign rdata = {{PAD_W{1'b0}}, rd_bits};

    for (genvar i = 0; i < N_PINS; i++) begin : g_chk
        assert_tx_forces_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
            per_tx_en[i] |-> (pin_oe[i] && pin_out[i] == per_tx_data[i]));
        assert_rx_forces_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (per_rx_en[i] && !per_tx_en[i]) |-> !pin_oe[i]);
        assert_tx_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (per_rx_en[i] && per_tx_en[i]) |-> pin_oe[i]);
        assert_dir_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!per_rx_en[i] && !per_tx_en[i]) |-> (pin_oe[i] == ddr_q[i]));
    end
endmodule

// File: tb/sim_gpio_port_ovr.sv
`timescale 1ns/100ps
module sim_gpio_port_ovr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [5:0] pin_in = 6'd0;
    logic [5:0] pin_out, pin_oe;
    logic [5:0] tx_en = 6'd0, rx_en = 6'd0, tx_d = 6'd0;

    int    n_checks = 0;
    int    n_errors = 0;
    string phase = "R2 reset";

    always #4 clk = ~clk;

    gpio_port_ovr u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .per_tx_en(tx_en), .per_rx_en(rx_en), .per_tx_data(tx_d)
    );

    // Reference model
    bit [5:0] m_dir = 0, m_dat = 0;
    int       lvl_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0;
            m_dat = 0;
            lvl_q = {0, 0};
        end else begin
            if (wr_en && addr == 2'd2) m_dir = wdata[5:0];
            if (wr_en && addr == 2'd0) m_dat = wdata[5:0];
            lvl_q.push_back(int'(pin_in));
            void'(lvl_q.pop_front());
        end
    end

    function automatic bit [5:0] exp_oe();
        bit [5:0] r;
        for (int i = 0; i < 6; i++)
            r[i] = tx_en[i] ? 1'b1 : (rx_en[i] ? 1'b0 : m_dir[i]);
        return r;
    endfunction

    function automatic bit [5:0] exp_out();
        bit [5:0] r;
        for (int i = 0; i < 6; i++)
            r[i] = tx_en[i] ? tx_d[i] : m_dat[i];
        return r;
    endfunction

    function automatic bit [7:0] exp_rd(int a);
        bit [5:0] lv;
        bit [5:0] oe;
        lv = lvl_q[0][5:0];
        oe = exp_oe();
        case (a)
            0:       return {2'b00, (oe & m_dat) | (~oe & lv)};
            1:       return {2'b00, lv};
            2:       return {2'b00, m_dir};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        logic [1:0] keep;
        @(negedge clk);
        keep = addr;
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a);
            #0.2;
            chk($sformatf("rdata addr%0d", a), rdata, exp_rd(a));
        end
        addr = keep;
        #0.2;
        chk("pin_oe", {2'b00, pin_oe}, {2'b00, exp_oe()});
        chk("pin_out", {2'b00, pin_out}, {2'b00, exp_out()});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1;
        addr = a;
        wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    bit [5:0] lfsr = 6'h2d;

    task automatic step_lfsr();
        lfsr = {lfsr[4:0], lfsr[5] ^ lfsr[4]};
    endtask

    initial begin : main
        phase = "R2 reset";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        phase = "R1 R4 direction write";
        wr(2'd2, 8'hFF);
        cyc();
        wr(2'd2, 8'h15);
        cyc();

        phase = "R3 output drive";
        wr(2'd0, 8'h2A);
        pin_in = 6'h3F;
        repeat (4) cyc();

        phase = "R8 R9 input sync";
        for (int k = 0; k < 48; k++) begin
            step_lfsr();
            pin_in = lfsr;
            if (k % 8 == 7) begin
                step_lfsr();
                wr(2'd2, {2'b11, lfsr});
            end else begin
                cyc();
            end
        end

        phase = "R5 transmit override";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        tx_en = 6'h0F;
        for (int k = 0; k < 8; k++) begin
            tx_d = 6'(k * 5);
            pin_in = 6'(k * 11);
            cyc();
        end

        phase = "R6 receive override";
        tx_en = 6'h00;
        wr(2'd2, 8'h3F);
        wr(2'd0, 8'h3F);
        rx_en = 6'h33;
        for (int k = 0; k < 6; k++) begin
            pin_in = 6'(k * 7);
            cyc();
        end

        phase = "R10 transmit priority";
        tx_en = 6'h0C;
        rx_en = 6'h3C;
        tx_d = 6'h04;
        repeat (4) cyc();

        phase = "R7 release restores direction";
        tx_en = 6'h00;
        rx_en = 6'h00;
        repeat (4) cyc();
        wr(2'd2, 8'h05);
        repeat (3) cyc();

        phase = "R11 ignored writes";
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'hFF);
        wr(2'd1, 8'h00);
        repeat (3) cyc();

        phase = "R2 reset again";
        rst_n = 1'b0;
        repeat (2) cyc();
        rst_n = 1'b1;
        cyc();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : watchdog
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule